// File: doc/BRIEF.md
# PHY Discovery and Link Resolution Sequencer

This block brings up an Ethernet link on its own. A one-cycle start pulse makes it search the management bus for an attached PHY. It reads the identifier-1 register (register 2) at every PHY address in turn, from 0 upwards. Once it finds a PHY, it reads that PHY's basic control register once. It then keeps reading the basic status register until the link is up and auto-negotiation has settled, or until a link timeout expires. From what it has read, it works out the operating speed and duplex that a MAC should use.

The block drives an external management-port model through a request/response handshake. It holds a request with a PHY address and register number until the port returns a done pulse with read data, or until a per-access timeout expires. Every timeout is counted in ticks from a parameterised prescaler, so a simulation can shorten the real-time values (half a second per access, four seconds for the link). The result appears on four output fields together with a one-cycle done pulse, and those fields then hold.

Top module: `phy_link_seq`

## Requirements
- R1: After reset, `done`, `mgmtReq`, `linkUp`, `speed100`, `fullDuplex` and `phyAddr` are all zero.
- R2: The scan reads register 2 at PHY addresses 0, 1, 2 and so on in ascending order. It stops at the first address that returns neither 0x0000 nor 0xFFFF, and `phyAddr` reports that address.
- R3: A read that gets no done within `MDIO_TICKS` prescaler ticks is abandoned and treated as 0xFFFF. A silent address is therefore skipped during the scan.
- R4: When no address yields a PHY, the result is `linkUp`=0, `speed100`=1, `fullDuplex`=1 and `phyAddr`=0.
- R5: After discovery, register 0 (control) is read exactly once. Register 1 (status) is then polled until bit 2 (link) is set and either control bit 12 (auto-negotiation enable) is clear or status bit 5 (negotiation complete) is set.
- R6: If the link bit is still clear when `LINK_TICKS` ticks have run out, the result is `linkUp`=0, `speed100`=1 and `fullDuplex`=1.
- R7: When negotiation is enabled and complete, registers 4 and 5 are read and ANDed together. The mode is chosen from the common bits in this priority order: bit 8 gives 100 full, bit 7 gives 100 half, bit 6 gives 10 full, bit 5 gives 10 half. If none of these bits is common, the result is 100 full.
- R8: When the link is up but negotiation is disabled, or did not complete before the link timeout, `speed100` is control bit 13 and `fullDuplex` is control bit 8, with `linkUp`=1.
- R9: `done` is high for exactly one cycle per run. The four result outputs change only on that cycle and hold their values until the next run's done.
- R10: A start pulse that arrives while a run is in progress is ignored. The run yields one done, and no further run follows.
- R11: While `mgmtReq` is high, `mgmtPhyAddr` and `mgmtRegAddr` stay stable. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| mgmtReq | output | 1 | Read request, held until done or timeout |
| mgmtPhyAddr | output | 5 | PHY address of the current access |
| mgmtRegAddr | output | 5 | Register number of the current access |
| mgmtDone | input | 1 | One-cycle completion from the management port |
| mgmtRdData | input | 16 | Read data, valid with mgmtDone |
| phyAddr | output | 5 | Discovered PHY address (0 if none) |
| linkUp | output | 1 | Link established |
| speed100 | output | 1 | 100 Mb/s selected (otherwise 10) |
| fullDuplex | output | 1 | Full duplex selected |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions assume three things about the management port. It raises `mgmtDone` only while `mgmtReq` is high. It raises it at most once per request. It never raises it in the cycle right after the request drops. The bench's port model keeps to these assumptions: it answers each request once, after a fixed latency of one to four cycles, and it stays silent on a chosen address so that the timeout path is exercised. The model keeps its status-register link and negotiation-complete delays well inside the link window, or makes them never occur. This keeps every expected outcome free of any dependence on exactly when the timeout expires.

// File: rtl/phy_link_pkg.sv
package phy_link_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_RD_CTRL,
    ST_POLL,
    ST_RD_ADV,
    ST_RD_LPA
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearRun;
    logic nextAddr;
    logic markFound;
    logic loadCtrl;
    logic loadStat;
    logic loadAdv;
    logic loadLpa;
    logic commit;
  } dpCmd_t;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  // management register numbers
  localparam logic [4:0] REG_CTRL = 5'd0;
  localparam logic [4:0] REG_STAT = 5'd1;
  localparam logic [4:0] REG_ID1  = 5'd2;
  localparam logic [4:0] REG_ADV  = 5'd4;
  localparam logic [4:0] REG_LPA  = 5'd5;

  // bit positions
  localparam int B_CTRL_FD    = 8;
  localparam int B_CTRL_AN    = 12;
  localparam int B_CTRL_SPD   = 13;
  localparam int B_STAT_LINK  = 2;
  localparam int B_STAT_ANDON = 5;
  localparam int B_AB_10H     = 5;
  localparam int B_AB_10F     = 6;
  localparam int B_AB_100H    = 7;
  localparam int B_AB_100F    = 8;

endpackage

// File: rtl/phy_link_ctrl.sv
module phy_link_ctrl
  import phy_link_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              xferEnd,
  input  logic [DATA_W-1:0] rdData,
  input  logic              lastAddr,
  input  logic              anEnabled,
  input  logic              linkExpired,
  output dpCmd_t            cmd,
  output logic              reqOn,
  output logic [4:0]        regSel
);

  seqState_t state, nState;
  logic nReq;
  logic idValid, statOk;

  assign idValid = (rdData != 16'h0000) && (rdData != 16'hFFFF);
  assign statOk  = rdData[B_STAT_LINK] && (!anEnabled || rdData[B_STAT_ANDON]);

  always_comb begin
    case (state)
      ST_SCAN:    regSel = REG_ID1;
      ST_RD_CTRL: regSel = REG_CTRL;
      ST_POLL:    regSel = REG_STAT;
      ST_RD_ADV:  regSel = REG_ADV;
      ST_RD_LPA:  regSel = REG_LPA;
      default:    regSel = REG_CTRL;
    endcase
  end

  always_comb begin
    cmd    = '0;
    nState = state;
    nReq   = reqOn;
    if (state == ST_IDLE) begin
      nReq = 1'b0;
      if (start) begin
        cmd.clearRun = 1'b1;
        nState       = ST_SCAN;
      end
    end else if (!reqOn) begin
      nReq = 1'b1;
    end else if (xferEnd) begin
      nReq = 1'b0;
      case (state)
        ST_SCAN: begin
          if (idValid) begin
            cmd.markFound = 1'b1;
            nState        = ST_RD_CTRL;
          end else if (lastAddr) begin
            cmd.commit = 1'b1;
            nState     = ST_IDLE;
          end else begin
            cmd.nextAddr = 1'b1;
          end
        end
        ST_RD_CTRL: begin
          cmd.loadCtrl = 1'b1;
          nState       = ST_POLL;
        end
        ST_POLL: begin
          cmd.loadStat = 1'b1;
          if (statOk) begin
            if (anEnabled) nState = ST_RD_ADV;
            else begin
              cmd.commit = 1'b1;
              nState     = ST_IDLE;
            end
          end else if (linkExpired) begin
            cmd.commit = 1'b1;
            nState     = ST_IDLE;
          end
        end
        ST_RD_ADV: begin
          cmd.loadAdv = 1'b1;
          nState      = ST_RD_LPA;
        end
        ST_RD_LPA: begin
          cmd.loadLpa = 1'b1;
          cmd.commit  = 1'b1;
          nState      = ST_IDLE;
        end
        default: nState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      reqOn <= 1'b0;
    end else begin
      state <= nState;
      reqOn <= nReq;
    end
  end

  // R11
  reg_sel_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqOn && $past(reqOn)) |-> $stable(regSel));

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && start) |-> !cmd.clearRun);

endmodule

// File: rtl/phy_link_dp.sv
module phy_link_dp
  import phy_link_pkg::*;
#(
  parameter int TICK_CYCLES = 50000,
  parameter int MDIO_TICKS  = 500,
  parameter int LINK_TICKS  = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              reqOn,
  input  logic              mgmtDone,
  input  logic [DATA_W-1:0] mgmtRdData,
  output logic              xferEnd,
  output logic [DATA_W-1:0] rdData,
  output logic              lastAddr,
  output logic              anEnabled,
  output logic              linkExpired,
  output logic [ADDR_W-1:0] scanAddr,
  output logic [ADDR_W-1:0] phyAddr,
  output logic              linkUp,
  output logic              speed100,
  output logic              fullDuplex,
  output logic              done
);

  localparam int PRE_W  = $clog2(TICK_CYCLES + 1);
  localparam int MDIO_W = $clog2(MDIO_TICKS + 1);
  localparam int LINK_W = $clog2(LINK_TICKS + 1);
  localparam logic [ADDR_W-1:0] MAX_ADDR = '1;

  logic [PRE_W-1:0]  preCnt;
  logic              tick;
  logic [MDIO_W-1:0] mdioCnt;
  logic [LINK_W-1:0] linkCnt;
  logic              mdioExpired;
  logic              found;
  logic [DATA_W-1:0] ctrlQ, statQ, advQ, commonQ;
  logic [DATA_W-1:0] statNow, commonNow;
  logic              resLink, resSpd, resFd;

  assign tick        = (preCnt == PRE_W'(TICK_CYCLES - 1));
  assign mdioExpired = (mdioCnt == MDIO_W'(MDIO_TICKS));
  assign linkExpired = (linkCnt == LINK_W'(LINK_TICKS));
  assign xferEnd     = reqOn && (mgmtDone || mdioExpired);
  assign rdData      = mgmtDone ? mgmtRdData : 16'hFFFF;
  assign lastAddr    = (scanAddr == MAX_ADDR);
  assign anEnabled   = ctrlQ[B_CTRL_AN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (tick) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mdioCnt <= '0;
    else if (!reqOn) mdioCnt <= '0;
    else if (tick && !mdioExpired) mdioCnt <= mdioCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linkCnt <= '0;
    else if (cmd.clearRun || cmd.loadCtrl) linkCnt <= '0;
    else if (tick && !linkExpired) linkCnt <= linkCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanAddr <= '0;
      found    <= 1'b0;
      ctrlQ    <= '0;
      statQ    <= '0;
      advQ     <= '0;
      commonQ  <= '0;
    end else begin
      if (cmd.clearRun) begin
        scanAddr <= '0;
        found    <= 1'b0;
        ctrlQ    <= '0;
        statQ    <= '0;
        advQ     <= '0;
        commonQ  <= '0;
      end
      if (cmd.nextAddr)  scanAddr <= scanAddr + 1'b1;
      if (cmd.markFound) found    <= 1'b1;
      if (cmd.loadCtrl)  ctrlQ    <= rdData;
      if (cmd.loadStat)  statQ    <= rdData;
      if (cmd.loadAdv)   advQ     <= rdData;
      if (cmd.loadLpa)   commonQ  <= advQ & rdData;
    end
  end

  // values that may be loaded in the same cycle as the commit
  assign statNow   = cmd.loadStat ? rdData : statQ;
  assign commonNow = cmd.loadLpa ? (advQ & rdData) : commonQ;

  always_comb begin
    resLink = found && statNow[B_STAT_LINK];
    resSpd  = 1'b1;
    resFd   = 1'b1;
    if (resLink) begin
      if (ctrlQ[B_CTRL_AN] && statNow[B_STAT_ANDON]) begin
        if (commonNow[B_AB_100F]) begin
          resSpd = 1'b1; resFd = 1'b1;
        end else if (commonNow[B_AB_100H]) begin
          resSpd = 1'b1; resFd = 1'b0;
        end else if (commonNow[B_AB_10F]) begin
          resSpd = 1'b0; resFd = 1'b1;
        end else if (commonNow[B_AB_10H]) begin
          resSpd = 1'b0; resFd = 1'b0;
        end
      end else begin
        resSpd = ctrlQ[B_CTRL_SPD];
        resFd  = ctrlQ[B_CTRL_FD];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyAddr    <= '0;
      linkUp     <= 1'b0;
      speed100   <= 1'b0;
      fullDuplex <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= cmd.commit;
      if (cmd.commit) begin
        phyAddr    <= found ? scanAddr : '0;
        linkUp     <= resLink;
        speed100   <= resSpd;
        fullDuplex <= resFd;
      end
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(linkUp) && $stable(speed100) && $stable(fullDuplex) && $stable(phyAddr)));

  // R4
  down_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !linkUp) |-> (speed100 && fullDuplex));

  // R3
  req_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqOn && mdioExpired) |=> !reqOn);

endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_link_pkg::*;
#(
  parameter int TICK_CYCLES = 50000,
  parameter int MDIO_TICKS  = 500,
  parameter int LINK_TICKS  = 4000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        mgmtReq,
  output logic [4:0]  mgmtPhyAddr,
  output logic [4:0]  mgmtRegAddr,
  input  logic        mgmtDone,
  input  logic [15:0] mgmtRdData,
  output logic [4:0]  phyAddr,
  output logic        linkUp,
  output logic        speed100,
  output logic        fullDuplex,
  output logic        done
);

  dpCmd_t            cmd;
  logic              reqOn, xferEnd, lastAddr, anEnabled, linkExpired;
  logic [DATA_W-1:0] rdData;
  logic [ADDR_W-1:0] scanAddr;
  logic [4:0]        regSel;

  phy_link_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .xferEnd(xferEnd), .rdData(rdData), .lastAddr(lastAddr),
    .anEnabled(anEnabled), .linkExpired(linkExpired),
    .cmd(cmd), .reqOn(reqOn), .regSel(regSel)
  );

  phy_link_dp #(
    .TICK_CYCLES(TICK_CYCLES), .MDIO_TICKS(MDIO_TICKS), .LINK_TICKS(LINK_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reqOn(reqOn),
    .mgmtDone(mgmtDone), .mgmtRdData(mgmtRdData),
    .xferEnd(xferEnd), .rdData(rdData), .lastAddr(lastAddr),
    .anEnabled(anEnabled), .linkExpired(linkExpired), .scanAddr(scanAddr),
    .phyAddr(phyAddr), .linkUp(linkUp), .speed100(speed100),
    .fullDuplex(fullDuplex), .done(done)
  );

  assign mgmtReq     = reqOn;
  assign mgmtPhyAddr = scanAddr;
  assign mgmtRegAddr = regSel;

  // R11
  phy_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtReq && $past(mgmtReq)) |-> $stable(mgmtPhyAddr));

endmodule

// File: tb/phy_link_seq_bench.sv
module phy_link_seq_bench;

  localparam int NEVER = 99;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        mgmtReq;
  logic [4:0]  mgmtPhyAddr, mgmtRegAddr;
  logic        mgmtDone;
  logic [15:0] mgmtRdData;
  logic [4:0]  phyAddr;
  logic        linkUp, speed100, fullDuplex, done;

  int errors = 0;
  int checks = 0;

  // port model configuration (written only by the initial block)
  int          cfgAt = 32;
  int          cfgSilent = -1;
  int          cfgLat = 2;
  int          cfgLinkAfter = 0;
  int          cfgAnAfter = 0;
  logic [31:0] cfgFill = '0;
  logic [15:0] cfgId = 16'h0141;
  logic [15:0] cfgCtrl = '0, cfgAdv = '0, cfgLpa = '0;
  int          trialId = 0;

  // port model state (written only by the model process)
  int   lastTrial = 0;
  logic answered = 1'b0;
  int   waitCnt = 0;
  int   statReads = 0;
  int   ctrlReads = 0;
  int   scanNext = 0;
  int   scanErr = 0;
  logic reqPrev = 1'b0;
  int   totalDone = 0;

  always #2 clk = ~clk;

  phy_link_seq #(.TICK_CYCLES(4), .MDIO_TICKS(8), .LINK_TICKS(50)) u_phy_link_seq (
    .clk(clk), .rstN(rstN), .start(start),
    .mgmtReq(mgmtReq), .mgmtPhyAddr(mgmtPhyAddr), .mgmtRegAddr(mgmtRegAddr),
    .mgmtDone(mgmtDone), .mgmtRdData(mgmtRdData),
    .phyAddr(phyAddr), .linkUp(linkUp), .speed100(speed100),
    .fullDuplex(fullDuplex), .done(done)
  );

  function automatic logic [15:0] modelValue(int a, logic [4:0] r, int sr);
    logic [15:0] v;
    v = 16'hFFFF;
    if (a != cfgAt) begin
      if (r == 5'd2) v = cfgFill[a] ? 16'hFFFF : 16'h0000;
    end else begin
      case (r)
        5'd0: v = cfgCtrl;
        5'd1: begin
          v = 16'h0000;
          v[2] = (sr >= cfgLinkAfter);
          v[5] = (sr >= cfgAnAfter);
        end
        5'd2: v = cfgId;
        5'd4: v = cfgAdv;
        5'd5: v = cfgLpa;
        default: v = 16'hFFFF;
      endcase
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (done) totalDone <= totalDone + 1;
    reqPrev <= mgmtReq;
    if (!rstN) begin
      mgmtDone <= 1'b0;
      mgmtRdData <= '0;
      answered <= 1'b0;
      waitCnt <= 0;
    end else begin
      if (trialId != lastTrial) begin
        lastTrial <= trialId;
        statReads <= 0;
        ctrlReads <= 0;
        scanNext <= 0;
        scanErr <= 0;
      end else if (mgmtReq && !reqPrev && mgmtRegAddr == 5'd2) begin
        if (int'(mgmtPhyAddr) != scanNext) scanErr <= scanErr + 1;
        scanNext <= scanNext + 1;
      end
      mgmtDone <= 1'b0;
      if (!mgmtReq) begin
        answered <= 1'b0;
        waitCnt <= 0;
      end else if (!answered) begin
        if (waitCnt >= cfgLat && int'(mgmtPhyAddr) != cfgSilent) begin
          mgmtDone <= 1'b1;
          mgmtRdData <= modelValue(int'(mgmtPhyAddr), mgmtRegAddr, statReads);
          answered <= 1'b1;
          if (int'(mgmtPhyAddr) == cfgAt && mgmtRegAddr == 5'd1) statReads <= statReads + 1;
          if (int'(mgmtPhyAddr) == cfgAt && mgmtRegAddr == 5'd0) ctrlReads <= ctrlReads + 1;
        end else begin
          waitCnt <= waitCnt + 1;
        end
      end
    end
  end

  // expected {addr, link, speed100, fullDuplex}
  function automatic logic [7:0] expectOf();
    logic [15:0] c;
    if (cfgAt > 31) return {5'd0, 3'b011};
    if (cfgLinkAfter == NEVER) return {5'(cfgAt), 3'b011};
    if (cfgCtrl[12] && cfgAnAfter != NEVER) begin
      c = cfgAdv & cfgLpa;
      if (c[8]) return {5'(cfgAt), 3'b111};
      if (c[7]) return {5'(cfgAt), 3'b110};
      if (c[6]) return {5'(cfgAt), 3'b101};
      if (c[5]) return {5'(cfgAt), 3'b100};
      return {5'(cfgAt), 3'b111};
    end
    return {5'(cfgAt), 1'b1, cfgCtrl[13], cfgCtrl[8]};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runTrial(string tag, int busyStart);
    int d0, n;
    logic [7:0] e;
    e = expectOf();
    d0 = totalDone;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (busyStart != 0) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (totalDone == d0 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) begin
      check({tag, " watchdog"}, 0, 1);
      return;
    end
    // R2 R4 R7 R8 R6: resolved outputs
    check({tag, " R2 phyAddr"}, int'(phyAddr), int'(e[7:3]));
    check({tag, " R6 linkUp"}, int'(linkUp), int'(e[2]));
    check({tag, " R7 speed100"}, int'(speed100), int'(e[1]));
    check({tag, " R8 fullDuplex"}, int'(fullDuplex), int'(e[0]));
    // R2 ascending scan order
    check({tag, " R2 scan order"}, scanErr, 0);
    // R5 control register read once when a PHY exists
    if (cfgAt <= 31) check({tag, " R5 ctrl reads"}, ctrlReads, 1);
    repeat (4) @(negedge clk);
    // R9 single done
    check({tag, " R9 done count"}, totalDone - d0, 1);
    if (busyStart != 0) begin
      repeat (300) @(negedge clk);
      // R10 no second run
      check({tag, " R10 no rerun"}, totalDone - d0, 1);
      check({tag, " R10 req idle"}, int'(mgmtReq), 0);
    end
  endtask

  task automatic setCfg(int at, int sil, logic [15:0] ct, logic [15:0] ad, logic [15:0] lp,
                        int la, int aa);
    trialId++;
    cfgAt = at; cfgSilent = sil; cfgCtrl = ct; cfgAdv = ad; cfgLpa = lp;
    cfgLinkAfter = la; cfgAnAfter = aa;
    cfgFill = $urandom();
    cfgLat = 1 + ($urandom() % 4);
    cfgId = 16'h0100 + 16'($urandom() % 256);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [7:0] held;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", int'(done), 0);
    check("R1 mgmtReq", int'(mgmtReq), 0);
    check("R1 outputs", int'({phyAddr, linkUp, speed100, fullDuplex}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R7: PHY at 0, negotiation 100 full
    setCfg(0, -1, 16'h1000, 16'h01E0, 16'h01E0, 0, 0);
    runTrial("an100f", 0);
    // R7 priority: 100 half wins over 10 full
    setCfg(7, -1, 16'h1000, 16'h00E0, 16'h00C0, 1, 2);
    runTrial("an100h", 0);
    // R7 10 half only
    setCfg(12, -1, 16'h1000, 16'h0020, 16'h0120, 0, 3);
    runTrial("an10h", 0);
    // R7 no common bits -> default
    setCfg(3, -1, 16'h1000, 16'h0100, 16'h0060, 0, 0);
    runTrial("annone", 0);
    // R8 forced 10 full
    setCfg(31, -1, 16'h0100, 16'h01E0, 16'h01E0, 2, NEVER);
    runTrial("forced", 0);
    // R8 negotiation never completes, forced 100 half
    setCfg(9, -1, 16'h3000, 16'h01E0, 16'h01E0, 0, NEVER);
    runTrial("antmo", 0);
    // R3 silent address before the PHY
    setCfg(6, 2, 16'h2000, 16'h0, 16'h0, 0, 0);
    runTrial("silent", 0);
    // R4 no PHY at all
    setCfg(32, 5, 16'h0, 16'h0, 16'h0, 0, 0);
    runTrial("nophy", 0);
    // R6 link never comes up
    setCfg(4, -1, 16'h1000, 16'h01E0, 16'h01E0, NEVER, 0);
    runTrial("nolink", 0);
    // R10 start while busy
    setCfg(10, -1, 16'h1000, 16'h0040, 16'h0040, 1, 1);
    runTrial("busy", 1);

    // R9 outputs hold without a new start
    held = {phyAddr, linkUp, speed100, fullDuplex};
    setCfg(1, -1, 16'h0000, 16'h0, 16'h0, 0, 0);
    repeat (50) @(negedge clk);
    check("R9 hold", int'({phyAddr, linkUp, speed100, fullDuplex}), int'(held));

    for (int t = 0; t < 30; t++) begin
      int at, sil, la, aa;
      at  = ($urandom() % 8 == 0) ? 32 : int'($urandom() % 32);
      sil = (at > 0 && at < 32 && ($urandom() % 3 == 0)) ? int'($urandom() % at) : -1;
      la  = ($urandom() % 6 == 0) ? NEVER : int'($urandom() % 5);
      aa  = ($urandom() % 6 == 0) ? NEVER : int'($urandom() % 5);
      setCfg(at, sil, 16'($urandom()), 16'($urandom()), 16'($urandom()), la, aa);
      runTrial("rand", 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule